// File: doc/BRIEF.md
# Burst DMA Channel Engine

This block is one channel of a DMA engine. It moves data between memory and a fixed peripheral FIFO in whole bursts (32 bytes by default). Software sets it up through a small register window. It writes a source address, a destination address, a burst count and a byte-valid mask for the final burst, then sets the enable bit in the control register. The engine requests one burst at a time on a request/acknowledge handshake. After each acknowledged burst the memory-side address moves forward by one burst and the count drops by one. The final burst carries the programmed mask in place of an all-ones mask.

The transfer ends normally when the count runs out. Two other events end or flag it early. The peripheral can report a zero-length packet; if detection is enabled, this sets a status bit. Software can then request forced termination, which sets the same transfer-end flag as a normal finish. A bus error sets a stop flag and halts requests. The level interrupt follows the three flags, gated by an interrupt-enable bit.

Top module: `burst_dma_chan`

## Requirements
- R1: The register window is 32 bytes long and starts at 0x20 + 0x20*CHAN_IDX. Local offsets are: source 0x00, destination 0x04, count 0x08, control 0x14, final mask 0x18. Reads at any other address return 0, and writes there change nothing.
- R2: After reset, every register reads 0, except the control size field, which reads the fixed burst-size code (0x80 in total at 32-byte bursts). irq and burst_req are 0.
- R3: The count register keeps only its low 24 bits. Upper bits that are written read back as 0.
- R4: Control bit map: enable bit 0, transfer-end bit 1, stop bit 2, interrupt-enable bit 5, size field bits 7:6, direction bit 8 (1 = device to memory), null-packet status bit 12, null-detect enable bit 16, forced-termination request bit 24. The size field is read-only and reads 2'b10 for 32-byte bursts. Bit 24 always reads 0.
- R5: The channel is busy when enable=1 and transfer-end=0. It asserts burst_req while busy, the count is nonzero and stop=0. Each cycle with both burst_req and burst_ack advances the memory-side address by the burst size and decrements the count. The memory-side address is the destination when direction=1 and the source otherwise. The other address does not move.
- R6: An acknowledged burst at count 1 sets transfer-end on the next edge, and burst_req then falls. Enabling the channel with count 0 sets transfer-end one cycle later, with no burst.
- R7: burst_last is high on the burst issued at count 1. On that burst, burst_bmask equals the final-mask register. On every other burst it is all ones.
- R8: A null_pkt pulse sets the null-packet status bit only while the channel is busy and null-detect is enabled. Otherwise it is ignored.
- R9: A control write with bit 24 set, made while busy with null-packet status already set, sets transfer-end on the next edge, stops requests and leaves the count as it was. The same write with status clear has no effect on transfer-end.
- R10: bus_err while busy sets the stop flag, and burst_req falls.
- R11: irq equals interrupt-enable AND (transfer-end OR stop OR null-status). It stays high until those bits are cleared.
- R12: Writing 0 to transfer-end, stop or null-status clears that bit, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R13: While busy, writes to source, destination, count and mask are ignored.
- R14: burst_addr shows the current memory-side address on every burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| null_pkt | input | 1 | Peripheral saw a zero-length packet |
| bus_err | input | 1 | Transfer error from the fabric |
| burst_req | output | 1 | Burst request |
| burst_ack | input | 1 | Burst accepted this cycle |
| burst_addr | output | 32 | Memory-side address of the current burst |
| burst_last | output | 1 | Current burst is the final one |
| burst_bmask | output | BURST_BYTES | Byte-valid mask of the current burst |
| irq | output | 1 | Level interrupt |

## Verification
The interesting collision is the final burst acknowledgement landing in the same cycle as a forced-termination write. Both set transfer-end. The bench provokes it with a single-burst transfer whose acknowledge is held off until the null-packet status is pending. It then raises burst_ack in the same cycle as the control write. The correct result is transfer-end set, count 0, and the address moved exactly once by one burst. A second overlap is also driven: a null_pkt pulse in the same cycle as a write that clears null-status. The bit must stay set.

// File: rtl/burst_dma_pkg.sv
package burst_dma_pkg;

   // local register offsets inside a channel window
   localparam logic [4:0] OFS_SRC = 5'h00;
   localparam logic [4:0] OFS_DST = 5'h04;
   localparam logic [4:0] OFS_CNT = 5'h08;
   localparam logic [4:0] OFS_CTL = 5'h14;
   localparam logic [4:0] OFS_MSK = 5'h18;

   // control bit positions
   localparam int B_DE   = 0;
   localparam int B_TE   = 1;
   localparam int B_SP   = 2;
   localparam int B_IE   = 5;
   localparam int B_TS   = 6;
   localparam int B_DIR  = 8;
   localparam int B_NUL  = 12;
   localparam int B_NULE = 16;
   localparam int B_FTE  = 24;

   typedef struct packed {
      logic de;
      logic te;
      logic sp;
      logic ie;
      logic dir;
      logic nul;
      logic nule;
   } ctl_t;

endpackage

// File: rtl/burst_dma_ctrl.sv
module burst_dma_ctrl
   import burst_dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctl,
   input  ctl_t wf,
   input  logic wf_fte,
   input  logic null_evt,
   input  logic bus_err,
   input  logic done_hit,
   output ctl_t ctl_q,
   output logic busy,
   output logic run
);

   logic force_term;
   logic te_set;
   logic sp_set;
   logic nul_set;
   ctl_t nx;

   always_comb begin
      busy = ctl_q.de & ~ctl_q.te;
      run  = busy & ~ctl_q.sp;
   end

   // forced termination only acts on a pending null-packet status
   assign force_term = wr_ctl & wf_fte & ctl_q.nul & busy;
   assign te_set     = done_hit | force_term;
   assign sp_set     = bus_err & busy;
   assign nul_set    = null_evt & ctl_q.nule & busy;

   always_comb begin
      nx = ctl_q;
      if (wr_ctl) begin
         nx.de   = wf.de;
         nx.ie   = wf.ie;
         nx.dir  = wf.dir;
         nx.nule = wf.nule;
         nx.te   = ctl_q.te  & wf.te;
         nx.sp   = ctl_q.sp  & wf.sp;
         nx.nul  = ctl_q.nul & wf.nul;
      end
      // hardware sets take priority over software clears
      if (te_set)  nx.te  = 1'b1;
      if (sp_set)  nx.sp  = 1'b1;
      if (nul_set) nx.nul = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= nx;
   end

endmodule

// File: rtl/burst_dma_xfer.sv
module burst_dma_xfer #(
   parameter int CNT_W       = 24,
   parameter int BURST_BYTES = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_src,
   input  logic                   wr_dst,
   input  logic                   wr_cnt,
   input  logic                   wr_msk,
   input  logic [31:0]            wdata,
   input  logic                   busy,
   input  logic                   run,
   input  logic                   dir,
   input  logic                   burst_ack,
   output logic [31:0]            src_q,
   output logic [31:0]            dst_q,
   output logic [CNT_W-1:0]       cnt_q,
   output logic [BURST_BYTES-1:0] msk_q,
   output logic                   burst_req,
   output logic [31:0]            burst_addr,
   output logic                   burst_last,
   output logic [BURST_BYTES-1:0] burst_bmask,
   output logic                   done_hit
);

   localparam logic [31:0]      STEP    = 32'(BURST_BYTES);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic adv;
   logic cnt_zero;
   logic cnt_one;

   assign cnt_zero   = (cnt_q == '0);
   assign cnt_one    = (cnt_q == CNT_ONE);
   assign burst_req  = run & ~cnt_zero;
   assign adv        = burst_req & burst_ack;
   assign burst_last = burst_req & cnt_one;
   assign burst_addr = dir ? dst_q : src_q;
   assign done_hit   = (adv & cnt_one) | (run & cnt_zero);

   // per-byte valid selection for the outgoing burst
   for (genvar b = 0; b < BURST_BYTES; b++) begin : g_bmask
      assign burst_bmask[b] = burst_last ? msk_q[b] : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
         msk_q <= '0;
      end else if (!busy) begin
         if (wr_src) src_q <= wdata;
         if (wr_dst) dst_q <= wdata;
         if (wr_cnt) cnt_q <= wdata[CNT_W-1:0];
         if (wr_msk) msk_q <= wdata[BURST_BYTES-1:0];
      end else if (adv) begin
         if (dir) dst_q <= dst_q + STEP;
         else     src_q <= src_q + STEP;
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

endmodule

// File: rtl/burst_dma_chan.sv
module burst_dma_chan
   import burst_dma_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CHAN_IDX    = 0,
   parameter int CNT_W       = 24,
   parameter int BURST_BYTES = 32,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic                   null_pkt,
   input  logic                   bus_err,
   output logic                   burst_req,
   input  logic                   burst_ack,
   output logic [31:0]            burst_addr,
   output logic                   burst_last,
   output logic [BURST_BYTES-1:0] burst_bmask,
   output logic                   irq
);

   localparam int         OFS_W   = 5;
   localparam int         BLK_I   = CHAN_IDX + 1;
   localparam logic [1:0] TS_CODE = 2'($clog2(BURST_BYTES) - 3);

   // elaboration-time parameter checks
   if (BURST_BYTES != 8 && BURST_BYTES != 16 && BURST_BYTES != 32) begin : g_bad_bb
      $error("BURST_BYTES must be 8, 16 or 32");
   end
   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
      $error("CNT_W must be 1..24");
   end
   if (ADDR_W < 6 || (CHAN_IDX + 2) * 32 > (1 << ADDR_W)) begin : g_bad_addr
      $error("channel window does not fit in ADDR_W");
   end

   logic             in_blk;
   logic [OFS_W-1:0] ofs;
   logic             wr_src, wr_dst, wr_cnt, wr_ctl, wr_msk;
   ctl_t             wf;
   logic             wf_fte;
   ctl_t             ctl_q;
   logic             busy, run, done_hit;
   logic [31:0]      src_q, dst_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BURST_BYTES-1:0] msk_q;
   logic             irq_c;

   assign in_blk = (reg_addr[ADDR_W-1:OFS_W] == BLK_I[ADDR_W-OFS_W-1:0]);
   assign ofs    = reg_addr[OFS_W-1:0];
   assign wr_src = reg_we & in_blk & (ofs == OFS_SRC);
   assign wr_dst = reg_we & in_blk & (ofs == OFS_DST);
   assign wr_cnt = reg_we & in_blk & (ofs == OFS_CNT);
   assign wr_ctl = reg_we & in_blk & (ofs == OFS_CTL);
   assign wr_msk = reg_we & in_blk & (ofs == OFS_MSK);

   always_comb begin
      wf.de   = reg_wdata[B_DE];
      wf.te   = reg_wdata[B_TE];
      wf.sp   = reg_wdata[B_SP];
      wf.ie   = reg_wdata[B_IE];
      wf.dir  = reg_wdata[B_DIR];
      wf.nul  = reg_wdata[B_NUL];
      wf.nule = reg_wdata[B_NULE];
      wf_fte  = reg_wdata[B_FTE];
   end

   burst_dma_ctrl ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (wr_ctl),
      .wf       (wf),
      .wf_fte   (wf_fte),
      .null_evt (null_pkt),
      .bus_err  (bus_err),
      .done_hit (done_hit),
      .ctl_q    (ctl_q),
      .busy     (busy),
      .run      (run)
   );

   burst_dma_xfer #(
      .CNT_W       (CNT_W),
      .BURST_BYTES (BURST_BYTES)
   ) xfer_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_src      (wr_src),
      .wr_dst      (wr_dst),
      .wr_cnt      (wr_cnt),
      .wr_msk      (wr_msk),
      .wdata       (reg_wdata),
      .busy        (busy),
      .run         (run),
      .dir         (ctl_q.dir),
      .burst_ack   (burst_ack),
      .src_q       (src_q),
      .dst_q       (dst_q),
      .cnt_q       (cnt_q),
      .msk_q       (msk_q),
      .burst_req   (burst_req),
      .burst_addr  (burst_addr),
      .burst_last  (burst_last),
      .burst_bmask (burst_bmask),
      .done_hit    (done_hit)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (in_blk) begin
         case (ofs)
            OFS_SRC: reg_rdata = src_q;
            OFS_DST: reg_rdata = dst_q;
            OFS_CNT: reg_rdata = 32'(cnt_q);
            OFS_MSK: reg_rdata = 32'(msk_q);
            OFS_CTL: begin
               reg_rdata[B_DE]     = ctl_q.de;
               reg_rdata[B_TE]     = ctl_q.te;
               reg_rdata[B_SP]     = ctl_q.sp;
               reg_rdata[B_IE]     = ctl_q.ie;
               reg_rdata[B_TS+1:B_TS] = TS_CODE;
               reg_rdata[B_DIR]    = ctl_q.dir;
               reg_rdata[B_NUL]    = ctl_q.nul;
               reg_rdata[B_NULE]   = ctl_q.nule;
            end
            default: reg_rdata = '0;
         endcase
      end
   end

   assign irq_c = ctl_q.ie & (ctl_q.te | ctl_q.sp | ctl_q.nul);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

endmodule

// File: rtl/burst_dma_chk.sv
module burst_dma_chk #(
   parameter int CNT_W       = 24,
   parameter int BURST_BYTES = 32,
   parameter bit IRQ_REG     = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             te,
   input logic             sp,
   input logic             nul,
   input logic             burst_req,
   input logic             burst_ack,
   input logic             burst_last,
   input logic [31:0]      burst_addr,
   input logic             wr_ctl,
   input logic             wr_fte,
   input logic             wr_src,
   input logic             wr_cnt,
   input logic [31:0]      src_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             bus_err,
   input logic             irq
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_req_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req |-> busy);

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && burst_req && burst_ack && !wr_ctl) |=>
         burst_addr == $past(burst_addr) + 32'(BURST_BYTES));

   assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && burst_req && burst_ack && burst_last) |=> (te && !burst_req));

   assert_force_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && wr_ctl && wr_fte && nul && busy) |=> te);

   assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && bus_err && busy) |=> (sp && !burst_req));

   assert_src_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && busy && wr_src && !(burst_req && burst_ack)) |=> src_q == $past(src_q));

   assert_cnt_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && busy && wr_cnt && !(burst_req && burst_ack)) |=> cnt_q == $past(cnt_q));

   if (!IRQ_REG) begin : g_irq_chk
      assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (te || sp || nul));
   end

endmodule

bind burst_dma_chan burst_dma_chk #(
   .CNT_W       (CNT_W),
   .BURST_BYTES (BURST_BYTES),
   .IRQ_REG     (IRQ_REG)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .te         (ctl_q.te),
   .sp         (ctl_q.sp),
   .nul        (ctl_q.nul),
   .burst_req  (burst_req),
   .burst_ack  (burst_ack),
   .burst_last (burst_last),
   .burst_addr (burst_addr),
   .wr_ctl     (wr_ctl),
   .wr_fte     (wf_fte),
   .wr_src     (wr_src),
   .wr_cnt     (wr_cnt),
   .src_q      (src_q),
   .cnt_q      (cnt_q),
   .bus_err    (bus_err),
   .irq        (irq)
);

// File: tb/burst_dma_chan_tb.sv
module burst_dma_chan_tb_top;

   localparam logic [7:0] A_SRC = 8'h20;
   localparam logic [7:0] A_DST = 8'h24;
   localparam logic [7:0] A_CNT = 8'h28;
   localparam logic [7:0] A_CTL = 8'h34;
   localparam logic [7:0] A_MSK = 8'h38;
   localparam logic [31:0] C_DE = 32'h1, C_TE = 32'h2, C_SP = 32'h4, C_IE = 32'h20;
   localparam logic [31:0] C_TS = 32'h80, C_DIR = 32'h100, C_NUL = 32'h1000;
   localparam logic [31:0] C_NULE = 32'h10000, C_FTE = 32'h1000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        null_pkt = 1'b0;
   logic        bus_err = 1'b0;
   logic        burst_req;
   logic        burst_ack;
   logic [31:0] burst_addr;
   logic        burst_last;
   logic [31:0] burst_bmask;
   logic        irq;

   int  n_chk = 0;
   int  n_fail = 0;
   int  ack_mode = 0;
   logic [7:0] cyc = '0;
   bit  finished = 1'b0;

   // monitor state
   int          mon_cnt = 0;
   int          mon_n = 0;
   bit          mon_on = 1'b0;
   logic [31:0] mon_base = '0;
   logic [31:0] mon_mask = '0;
   logic [31:0] mon_lastmask = '0;

   always #2 clk = ~clk;

   assign burst_ack = (ack_mode == 1) | ((ack_mode == 2) & cyc[0]);

   always @(negedge clk) cyc <= cyc + 8'd1;

   burst_dma_chan dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .null_pkt(null_pkt),
      .bus_err(bus_err), .burst_req(burst_req), .burst_ack(burst_ack),
      .burst_addr(burst_addr), .burst_last(burst_last),
      .burst_bmask(burst_bmask), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
      logic [31:0] v;
      rd(a, v);
      check(v == e, tag, v, e);
   endtask

   task automatic pulse_null();
      @(negedge clk); null_pkt = 1'b1;
      @(negedge clk); null_pkt = 1'b0;
   endtask

   task automatic wait_irq(output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 400 && !seen; k++) begin
         @(negedge clk); #1;
         if (irq) seen = 1'b1;
      end
   endtask

   function automatic logic [31:0] tail_mask(input int len);
      int n;
      n = (len % 32 == 0) ? 32 : (len % 32);
      return 32'hFFFF_FFFF << (32 - n);
   endfunction

   // burst monitor, samples between edges
   always begin
      @(negedge clk); #1;
      if (burst_req && burst_ack) begin
         if (mon_on) begin
            check(burst_addr == mon_base + 32'(32 * mon_cnt), "R14 burst address",
                  burst_addr, mon_base + 32'(32 * mon_cnt));
            check(burst_last == (mon_cnt == mon_n - 1), "R7 last flag",
                  32'(burst_last), 32'(mon_cnt == mon_n - 1));
            if (mon_cnt == mon_n - 1) mon_lastmask = burst_bmask;
            else check(burst_bmask == 32'hFFFF_FFFF, "R7 full mask",
                       burst_bmask, 32'hFFFF_FFFF);
         end
         mon_cnt++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      expect_reg(A_SRC, 32'h0, "R2 src reset");
      expect_reg(A_DST, 32'h0, "R2 dst reset");
      expect_reg(A_CNT, 32'h0, "R2 cnt reset");
      expect_reg(A_MSK, 32'h0, "R2 mask reset");
      expect_reg(A_CTL, C_TS, "R2 ctl reset");
      check(irq == 1'b0 && burst_req == 1'b0, "R2 outputs", {irq, burst_req}, 0);

      // R1 window decode
      wr(8'h08, 32'h55);
      expect_reg(8'h08, 32'h0, "R1 outside read");
      expect_reg(A_CNT, 32'h0, "R1 outside write");
      expect_reg(8'h2C, 32'h0, "R1 hole read");

      // R3 count width
      wr(A_CNT, 32'hFF00_0005);
      expect_reg(A_CNT, 32'h5, "R3 upper bits");

      // R4 size field fixed, FTE reads 0
      wr(A_CTL, 32'h40 | C_IE | C_FTE);
      expect_reg(A_CTL, C_TS | C_IE, "R4 ts/fte readback");
      wr(A_CTL, 32'h0);

      // R5 R6 R7 R14 sweep over lengths, directions, ack patterns
      for (int len = 1; len <= 72; len++) begin
         int n;
         bit d;
         logic [31:0] sa, da, base;
         n  = (len + 31) / 32;
         d  = len[0];
         sa = 32'h1000 + 32'(len * 64);
         da = 32'h8000 + 32'(len * 128);
         base = d ? da : sa;
         wr(A_SRC, sa);
         wr(A_DST, da);
         wr(A_CNT, 32'(n));
         wr(A_MSK, tail_mask(len));
         mon_cnt = 0; mon_n = n; mon_base = base; mon_mask = tail_mask(len);
         mon_lastmask = '0; mon_on = 1'b1;
         ack_mode = (len % 3 == 0) ? 2 : 1;
         wr(A_CTL, C_DE | C_IE | C_NULE | (d ? C_DIR : 32'h0));
         wait_irq(seen);
         check(seen, "R6 transfer end irq", 32'(seen), 1);
         ack_mode = 0;
         repeat (2) @(negedge clk);
         mon_on = 1'b0;
         check(mon_cnt == n, "R5 burst count", 32'(mon_cnt), 32'(n));
         check(mon_lastmask == tail_mask(len), "R7 final mask", mon_lastmask, tail_mask(len));
         check(burst_req == 1'b0, "R6 req dropped", 32'(burst_req), 0);
         expect_reg(d ? A_DST : A_SRC, base + 32'(32 * n), "R5 memory address");
         expect_reg(d ? A_SRC : A_DST, d ? sa : da, "R5 other address");
         expect_reg(A_CNT, 32'h0, "R6 count exhausted");
         rd(A_CTL, v);
         check((v & C_TE) != 0, "R6 te flag", v, v | C_TE);
         wr(A_CTL, 32'h0);
         check(irq == 1'b0, "R12 clear irq", 32'(irq), 0);
      end

      // R6 zero count
      mon_cnt = 0;
      wr(A_CNT, 32'h0);
      wr(A_CTL, C_DE | C_IE);
      repeat (2) @(negedge clk); #1;
      check(irq == 1'b1 && mon_cnt == 0, "R6 zero count", {irq, 31'(mon_cnt)}, 32'h8000_0000);
      wr(A_CTL, 32'h0);

      // R11 interrupt masked
      wr(A_CTL, C_DE);
      repeat (2) @(negedge clk); #1;
      check(irq == 1'b0, "R11 ie off", 32'(irq), 0);
      expect_reg(A_CTL, C_TS | C_DE | C_TE, "R11 te without irq");
      wr(A_CTL, 32'h0);

      // R13 writes ignored while busy
      ack_mode = 0;
      wr(A_MSK, 32'h0);
      wr(A_SRC, 32'h100);
      wr(A_CNT, 32'h4);
      wr(A_CTL, C_DE);
      wr(A_SRC, 32'h999);
      wr(A_CNT, 32'h7);
      wr(A_MSK, 32'hF);
      expect_reg(A_SRC, 32'h100, "R13 src held");
      expect_reg(A_CNT, 32'h4, "R13 cnt held");
      expect_reg(A_MSK, 32'h0, "R13 mask held");

      // R8 null ignored without enable
      pulse_null();
      expect_reg(A_CTL, C_TS | C_DE, "R8 null ignored");

      // R9 FTE without pending null has no effect
      wr(A_CTL, C_DE | C_NULE | C_IE | C_FTE);
      expect_reg(A_CTL, C_TS | C_DE | C_NULE | C_IE, "R9 fte no null");
      check(burst_req == 1'b1, "R9 still requesting", 32'(burst_req), 1);

      // R8 null detected, R11 irq
      pulse_null();
      expect_reg(A_CTL, C_TS | C_DE | C_NULE | C_IE | C_NUL, "R8 null set");
      check(irq == 1'b1, "R11 irq on null", 32'(irq), 1);

      // R12 null event coincides with clearing write: set wins
      @(negedge clk);
      reg_we = 1'b1; reg_addr = A_CTL; reg_wdata = C_DE | C_NULE | C_IE; null_pkt = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; null_pkt = 1'b0;
      expect_reg(A_CTL, C_TS | C_DE | C_NULE | C_IE | C_NUL, "R12 set beats clear");

      // R12 writing 1 keeps, R9 forced termination
      wr(A_CTL, C_DE | C_NULE | C_IE | C_NUL);
      expect_reg(A_CTL, C_TS | C_DE | C_NULE | C_IE | C_NUL, "R12 write one keeps");
      wr(A_CTL, C_DE | C_NULE | C_IE | C_FTE);
      expect_reg(A_CTL, C_TS | C_DE | C_NULE | C_IE | C_TE, "R9 forced end");
      check(burst_req == 1'b0 && irq == 1'b1, "R9 req stop irq", {burst_req, irq}, 32'h1);
      expect_reg(A_CNT, 32'h4, "R9 count kept");
      wr(A_CTL, 32'h0);

      // collision: final ack and forced termination in one cycle
      wr(A_SRC, 32'h400);
      wr(A_CNT, 32'h1);
      mon_cnt = 0;
      wr(A_CTL, C_DE | C_NULE | C_IE);
      pulse_null();
      @(negedge clk);
      reg_we = 1'b1; reg_addr = A_CTL; reg_wdata = C_DE | C_NULE | C_IE | C_FTE; ack_mode = 1;
      @(negedge clk);
      reg_we = 1'b0; ack_mode = 0;
      expect_reg(A_CTL, C_TS | C_DE | C_NULE | C_IE | C_TE, "R9 R6 collision flags");
      expect_reg(A_CNT, 32'h0, "R6 collision count");
      expect_reg(A_SRC, 32'h420, "R5 collision address");
      check(mon_cnt == 1, "R5 collision bursts", 32'(mon_cnt), 1);
      wr(A_CTL, 32'h0);

      // R10 stop on bus error
      wr(A_CNT, 32'h3);
      wr(A_CTL, C_DE | C_IE);
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0;
      #1;
      check(burst_req == 1'b0 && irq == 1'b1, "R10 stop halts", {burst_req, irq}, 32'h1);
      expect_reg(A_CTL, C_TS | C_DE | C_IE | C_SP, "R10 sp flag");
      wr(A_CTL, C_DE | C_IE | C_SP);
      expect_reg(A_CTL, C_TS | C_DE | C_IE | C_SP, "R12 sp kept");
      wr(A_CTL, C_IE);
      #1;
      check(irq == 1'b0, "R11 irq cleared", 32'(irq), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule